// File: doc/BRIEF.md
# Sparse Prefix Carry-Select Adder

This block adds two 64-bit operands and a carry-in. It splits the operand into groups of `SPARSE` bits. Each group works out two local sums at the same time: one that assumes no carry enters the group, and one that assumes a carry does. A parallel-prefix tree works out one carry for each group boundary. That carry then picks which of the two local sums goes to the output. Inside the tree, each bit generates a carry when both operand bits are 1 (AND) and passes a carry on when either operand bit is 1 (OR). The sums themselves use the exclusive-or of the operand bits.

The carry-in enters the tree as the generate signal of an extra element below bit 0, so the tree handles it like any other carry. Two elaboration parameters set the shape of the tree: `RADIX` (2 or 4) is the number of spans that each tree node merges, and `SPARSE` (1, 2 or 4) is the spacing between computed carries. The parameter `OUT_REG` adds an output register for timing closure. That register is reset asynchronously.

Top module: `spa_adder`

## Requirements
- R1: `{cout, sum}` equals `a + b + cin` taken as a 65-bit unsigned sum, for every operand pair and for every supported `RADIX` and `SPARSE`.
- R2: `cin` = 1 adds exactly one to the result, so an all-ones `a`, zero `b` and `cin` = 1 give `sum` = 0 with `cout` = 1.
- R3: The carry entering each group boundary (bit positions that are multiples of `SPARSE`) equals the carry of the addition of all lower bits plus `cin`. `cout` is 1 exactly when the true sum reaches 2^64.
- R4: When every bit position only passes a carry on (`a` equals the complement of `b`), `sum` is all ones with `cout` = 0 when `cin` = 0, and `sum` is zero with `cout` = 1 when `cin` = 1.
- R5: Within each group, the local sum for carry 1 equals the local sum for carry 0 plus one, modulo 2^`SPARSE`.
- R6: All six combinations of `RADIX` in {2, 4} and `SPARSE` in {1, 2, 4} give the same outputs for the same inputs.
- R7: With `OUT_REG` = 1, `sum` and `cout` are 0 while `rst_n` is low. Otherwise they show the result of the operands sampled at the previous rising clock edge, and they hold it until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Sum bits |
| cout | output | 1 | Carry out of bit 63 |

## Verification
The assertions assume that `a`, `b` and `cin` are known values that are stable around each rising clock edge. The register check also assumes that reset stays low until at least one edge has passed. The bench changes its inputs only on falling edges and holds reset low for several cycles before it releases it on a falling edge. The corner vectors cover full-length carry chains, a carry generated in the top bit, and a carry-in that ripples through every group, so that every group-boundary carry and both local sums are exercised.

// File: rtl/spa_pkg.sv
package spa_pkg;

  // Number of tree levels needed so that RADIX**levels covers n elements.
  function automatic int unsigned tree_levels(input int unsigned n, input int unsigned r);
    int unsigned span;
    int unsigned lv;
    span = 1;
    lv   = 0;
    while (span < n) begin
      span = span * r;
      lv   = lv + 1;
    end
    return lv;
  endfunction

  // Merge up to four spans. Index 0 is the most significant span (the node itself).
  function automatic logic fold_g(input logic [3:0] g, input logic [3:0] p, input int unsigned r);
    logic ga;
    logic pa;
    ga = g[0];
    pa = p[0];
    for (int m = 1; m < 4; m++) begin
      if (m < r) begin
        ga = ga | (pa & g[m]);
        pa = pa & p[m];
      end
    end
    return ga;
  endfunction

  function automatic logic fold_p(input logic [3:0] p, input int unsigned r);
    logic pa;
    pa = p[0];
    for (int m = 1; m < 4; m++) begin
      if (m < r) pa = pa & p[m];
    end
    return pa;
  endfunction

endpackage

// File: rtl/spa_group.sv
module spa_group #(
  parameter int unsigned K = 4
) (
  input  logic [K-1:0] a,
  input  logic [K-1:0] b,
  output logic         grp_g,
  output logic         grp_p,
  output logic [K-1:0] sum0,
  output logic [K-1:0] sum1
);

  // Local ripple sum of one group for a given assumed carry-in.
  function automatic logic [K-1:0] local_sum(input logic [K-1:0] x, input logic [K-1:0] y,
                                             input logic c_in);
    logic [K-1:0] s;
    logic         c;
    logic         h;
    c = c_in;
    for (int i = 0; i < K; i++) begin
      h    = x[i] ^ y[i];
      s[i] = h ^ c;
      c    = (x[i] & y[i]) | (h & c);
    end
    return s;
  endfunction

  // Group generate and propagate for the tree (propagate in OR form).
  always_comb begin
    grp_g = 1'b0;
    grp_p = 1'b1;
    for (int i = 0; i < K; i++) begin
      grp_g = (a[i] & b[i]) | ((a[i] | b[i]) & grp_g);
      grp_p = grp_p & (a[i] | b[i]);
    end
  end

  assign sum0 = local_sum(a, b, 1'b0);
  assign sum1 = local_sum(a, b, 1'b1);

endmodule

// File: rtl/spa_prefix_tree.sv
module spa_prefix_tree
  import spa_pkg::*;
#(
  parameter int unsigned N     = 17,
  parameter int unsigned RADIX = 4
) (
  input  logic [N-1:0] g_in,
  input  logic [N-1:0] p_in,
  output logic [N-1:0] g_out
);

  localparam int unsigned LEVELS = tree_levels(N, RADIX);

  logic [LEVELS:0][N-1:0]   lg;
  logic [LEVELS-1:0][N-1:0] lp;

  assign lg[0] = g_in;
  assign lp[0] = p_in;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int SPAN = RADIX ** l;
    for (genvar i = 0; i < N; i++) begin : g_node
      logic [3:0] og;
      logic [3:0] op;
      for (genvar m = 0; m < 4; m++) begin : g_opnd
        if ((m < RADIX) && (i - m * SPAN >= 0)) begin : g_live
          assign og[m] = lg[l][i - m * SPAN];
          assign op[m] = lp[l][i - m * SPAN];
        end else begin : g_idle
          assign og[m] = 1'b0;
          assign op[m] = 1'b1;
        end
      end
      assign lg[l+1][i] = fold_g(og, op, RADIX);
      if (l + 1 < LEVELS) begin : g_keep_p
        assign lp[l+1][i] = fold_p(op, RADIX);
      end
    end
  end

  assign g_out = lg[LEVELS];

endmodule

// File: rtl/spa_adder.sv
module spa_adder #(
  parameter int unsigned WIDTH   = 64,
  parameter int unsigned RADIX   = 4,
  parameter int unsigned SPARSE  = 4,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  // RADIX must be 2 or 4; SPARSE must be 1, 2 or 4 and divide WIDTH.
  localparam int unsigned NG = WIDTH / SPARSE;
  localparam int unsigned NE = NG + 1;

  // Element 0 stands for the carry-in; element g+1 is group g.
  logic [NE-1:0]    elem_g;
  logic [NE-1:0]    elem_p;
  logic [NE-1:0]    pfx_carry;   // carry into group g, pfx_carry[NG] = carry out
  logic [WIDTH-1:0] cond_sum0;
  logic [WIDTH-1:0] cond_sum1;
  logic [WIDTH-1:0] raw_sum;
  logic             raw_cout;

  assign elem_g[0] = cin;
  assign elem_p[0] = 1'b0;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    spa_group #(.K(SPARSE)) u_grp (
      .a     (a[gi*SPARSE +: SPARSE]),
      .b     (b[gi*SPARSE +: SPARSE]),
      .grp_g (elem_g[gi+1]),
      .grp_p (elem_p[gi+1]),
      .sum0  (cond_sum0[gi*SPARSE +: SPARSE]),
      .sum1  (cond_sum1[gi*SPARSE +: SPARSE])
    );
    assign raw_sum[gi*SPARSE +: SPARSE] = pfx_carry[gi] ? cond_sum1[gi*SPARSE +: SPARSE]
                                                        : cond_sum0[gi*SPARSE +: SPARSE];
  end

  spa_prefix_tree #(.N(NE), .RADIX(RADIX)) u_tree (
    .g_in  (elem_g),
    .p_in  (elem_p),
    .g_out (pfx_carry)
  );

  assign raw_cout = pfx_carry[NG];

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= raw_sum;
        cout <= raw_cout;
      end
    end
  end else begin : g_comb
    assign sum  = raw_sum;
    assign cout = raw_cout;
  end

endmodule

// File: rtl/spa_adder_chk.sv
module spa_adder_chk #(
  parameter int unsigned WIDTH   = 64,
  parameter int unsigned SPARSE  = 4,
  parameter bit          OUT_REG = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [WIDTH-1:0]        a,
  input logic [WIDTH-1:0]        b,
  input logic                    cin,
  input logic [WIDTH-1:0]        sum,
  input logic                    cout,
  input logic [WIDTH-1:0]        raw_sum,
  input logic                    raw_cout,
  input logic [WIDTH/SPARSE:0]   pfx_carry,
  input logic [WIDTH-1:0]        cond_sum0,
  input logic [WIDTH-1:0]        cond_sum1
);

  localparam int unsigned NG = WIDTH / SPARSE;

  logic [WIDTH:0] full_total;
  assign full_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  AST_RAW_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    {raw_cout, raw_sum} == full_total) else $error("raw total mismatch"); // R1

  AST_CIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_carry[0] == cin) else $error("carry-in entry mismatch"); // R2

  AST_FULL_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (a == ~b) |-> ((raw_cout == cin) && (raw_sum == {WIDTH{~cin}}))) else $error("chain"); // R4

  for (genvar gi = 0; gi < NG; gi++) begin : g_chk
    localparam int unsigned LO = gi * SPARSE;
    logic [WIDTH:0] msk;
    logic [WIDTH:0] low_total;
    assign msk       = ({{WIDTH{1'b0}}, 1'b1} << LO) - 1'b1;
    assign low_total = ({1'b0, a} & msk) + ({1'b0, b} & msk) + {{WIDTH{1'b0}}, cin};

    AST_GROUP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      pfx_carry[gi] == low_total[LO]) else $error("group carry mismatch"); // R3

    AST_COND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      cond_sum1[LO +: SPARSE] == cond_sum0[LO +: SPARSE] + 1'b1) else $error("cond step"); // R5
  end

  if (OUT_REG) begin : g_reg_chk
    logic started;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
    end

    AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> ({cout, sum} == $past({raw_cout, raw_sum}))) else $error("reg delay"); // R7
  end

endmodule

bind spa_adder spa_adder_chk #(.WIDTH(WIDTH), .SPARSE(SPARSE), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a         (a),
  .b         (b),
  .cin       (cin),
  .sum       (sum),
  .cout      (cout),
  .raw_sum   (raw_sum),
  .raw_cout  (raw_cout),
  .pfx_carry (pfx_carry),
  .cond_sum0 (cond_sum0),
  .cond_sum1 (cond_sum1)
);

// File: tb/spa_adder_test.sv
`timescale 1ns/1ps
module spa_adder_test;

  localparam int NCFG = 6;
  localparam int W    = 64;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic         co;
    logic [W-1:0] s;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{64'h0, 64'h0, 1'b0, 1'b0, 64'h0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b1, 64'h0},                                    // R3
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b1, 64'h0},                                    // R2
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, // R4
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, 1'b1, 64'h0},                  // R4
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 64'h0},                  // R3
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b0, 64'h8000_0000_0000_0000},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
    '{64'h0F0F_0F0F_0F0F_0F0F, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, 1'b0, 64'h1E1E_1E1E_1E1E_1E1E},
    '{64'h0000_0000_FFFF_FFFF, 64'h1, 1'b0, 1'b0, 64'h0000_0001_0000_0000},
    '{64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0, 1'b0, 64'h2222_2222_2222_2211}
  };

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         cin;
  logic [W-1:0] sum_o  [NCFG];
  logic         cout_o [NCFG];

  int  total;
  int  bad;
  bit  done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  for (genvar ci = 0; ci < NCFG; ci++) begin : g_cfg
    localparam int RX = (ci < 3) ? 2 : 4;
    localparam int SP = (ci % 3 == 0) ? 1 : ((ci % 3 == 1) ? 2 : 4);
    logic [W-1:0] s_w;
    logic         c_w;
    spa_adder #(.WIDTH(W), .RADIX(RX), .SPARSE(SP), .OUT_REG(1'b1)) uut (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (a),
      .b     (b),
      .cin   (cin),
      .sum   (s_w),
      .cout  (c_w)
    );
    assign sum_o[ci]  = s_w;
    assign cout_o[ci] = c_w;
  end

  task automatic check_all(input string tag, input logic co_e, input logic [W-1:0] s_e);
    for (int ci = 0; ci < NCFG; ci++) begin
      total++;
      if (sum_o[ci] !== s_e || cout_o[ci] !== co_e) begin
        bad++;
        $display("FAIL %s cfg%0d: actual cout=%0b sum=%h expected cout=%0b sum=%h",
                 tag, ci, cout_o[ci], sum_o[ci], co_e, s_e);
      end
    end
  endtask

  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(negedge clk);
    a   = av;
    b   = bv;
    cin = cv;
  endtask

  task automatic run_vec(input string tag, input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic cv);
    logic [W:0] ref_total;
    ref_total = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    drive(av, bv, cv);
    @(negedge clk);
    check_all(tag, ref_total[W], ref_total[W-1:0]);
  endtask

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    a     = 64'h5;
    b     = 64'h6;
    cin   = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R7 reset clear", 1'b0, 64'h0);

    rst_n = 1'b1;
    @(negedge clk);
    check_all("R7 first capture", 1'b0, 64'hB);

    // New operands at the falling edge; outputs must hold until the next rising edge.
    a   = 64'hFFFF_FFFF_FFFF_FFFF;
    b   = 64'h1;
    cin = 1'b0;
    #1;
    check_all("R7 hold", 1'b0, 64'hB);
    @(negedge clk);
    check_all("R7 next result", 1'b1, 64'h0);

    for (int v = 0; v < NVEC; v++) begin
      drive(VECS[v].a, VECS[v].b, VECS[v].cin);
      @(negedge clk);
      check_all($sformatf("R1/R6 table %0d", v), VECS[v].co, VECS[v].s);
    end

    // R3: carry out of the top bit exactly at the 2^64 boundary
    run_vec("R3 below boundary", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
    run_vec("R3 at boundary",    64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);

    // R5: toggling the carry-in moves the result by exactly one
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      run_vec("R5 cin low",  ra, rb, 1'b0);
      run_vec("R5 cin high", ra, rb, 1'b1);
    end

    // R2: a carry-in rippling through every group
    run_vec("R2 ripple", 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);

    // R4: complementary random operands pass a carry on at every bit
    for (int k = 0; k < 10; k++) begin
      logic [W-1:0] ra;
      ra = {$urandom, $urandom};
      run_vec("R4 chain", ra, ~ra, k[0]);
    end

    // R1 and R6: random operands across all configurations
    for (int k = 0; k < 300; k++) begin
      run_vec("R1 random", {$urandom, $urandom}, {$urandom, $urandom}, $urandom % 2);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual finished=0 expected finished=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule